// File: doc/BRIEF.md
# Toggle Bit Completion Poller

This block runs on the host side of a flash memory. It decides when a program or erase operation inside the device has finished. After a one-cycle start pulse it reads the device status byte over a simple request/response port, always in pairs of consecutive reads. It then compares the toggle bit (bit 6) between the two reads of each pair.

A toggle bit that holds still means the operation is complete. A toggle bit that keeps flipping means the operation is still running. If the timeout flag (bit 5) is seen while the toggle bit is flipping, the poller makes one more pair of reads before it gives up.

The result is reported as a one-cycle pulse on either a completion output or a failure output. A failure is always paired with a pulse on a reset-command request, which tells the host to return the device to read mode. A programmable limit on the number of changing pairs makes sure the poller never waits forever.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: A start pulse taken in idle makes `rd_req_o` rise in the next cycle. Each later read request is raised in the cycle right after the response to the previous read.
- R2: At most one read is outstanding. `rd_req_o` is a one-cycle pulse and is not raised again until `rd_ack_i` has returned.
- R3: When bit 6 of the two reads of a pair is equal, `done_o` pulses in the cycle after the second response. Every other status bit (7, 5..0) is ignored for this decision.
- R4: When bit 6 differs within a pair and bit 5 of the second read is 0, a new pair of reads starts. Bit 5 of the first read has no effect.
- R5: When bit 6 differs and bit 5 of the second read is 1, exactly one recheck pair is read. If bit 6 is equal in the recheck pair, `done_o` pulses. The pair limit does not apply to this recheck.
- R6: When bit 6 still differs in the recheck pair, `fail_o` and `reset_cmd_o` pulse together in the cycle after the second response.
- R7: `max_polls_i` is sampled at start. When the number of changing pairs with bit 5 clear reaches that value, `fail_o` and `reset_cmd_o` pulse. A value of 0 acts as 1.
- R8: `done_o` and `fail_o` are single-cycle pulses and never both high. After either one, the block is idle and issues no read until the next start.
- R9: A start pulse while an operation is in progress is ignored. The read count and the verdict of that operation are unchanged.
- R10: While reset is asserted, and after it is released, every output is 0. A reset during an operation abandons that operation without a verdict. A response that arrives while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin polling |
| max_polls_i | input | CNT_W | Limit on changing pairs, sampled at start (0 acts as 1) |
| rd_req_o | output | 1 | One-cycle status read request |
| rd_ack_i | input | 1 | Status read response valid |
| rd_data_i | input | DATA_W | Status byte returned with `rd_ack_i` |
| done_o | output | 1 | One-cycle pulse: operation complete |
| fail_o | output | 1 | One-cycle pulse: operation failed |
| reset_cmd_o | output | 1 | One-cycle pulse asking the host to issue the reset command |

## Verification
The first read request is due one cycle after the start pulse is sampled. Every later request is due one cycle after the previous response. The verdict pulse is due one cycle after the last response of the deciding pair.

The bench samples all outputs at the falling edge and timestamps each request, response and verdict with a cycle counter. It then checks these exact one-cycle offsets, together with the total number of reads, for a set of status-byte scripts that are played back at several response latencies. In the cycle after each verdict it confirms that the pulse has dropped and that no further read follows.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ISSUE_A = 3'd1,
    ST_WAIT_A  = 3'd2,
    ST_ISSUE_B = 3'd3,
    ST_WAIT_B  = 3'd4
  } tbp_state_e;
endpackage

// File: rtl/tbp_pair_judge.sv
// Holds the toggle bit of the first read of a pair and judges the pair
// when the second response arrives.
module tbp_pair_judge #(
  parameter int DATA_W      = 8,
  parameter int TOGGLE_IDX  = 6,
  parameter int TIMEOUT_IDX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] rd_data,
  output logic              toggled,
  output logic              timeout_seen
);
  logic first_tog_q;
  logic first_tog_d;

  always_comb begin
    first_tog_d = first_tog_q;
    if (cap_en) first_tog_d = rd_data[TOGGLE_IDX];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_tog_q <= 1'b0;
    else        first_tog_q <= first_tog_d;
  end

  assign toggled      = first_tog_q ^ rd_data[TOGGLE_IDX];
  assign timeout_seen = rd_data[TIMEOUT_IDX];
endmodule

// File: rtl/tbp_poll_limit.sv
// Counts pairs whose toggle bit changed and flags when the limit is reached.
module tbp_poll_limit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit_i,
  output logic             limit_hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [CNT_W:0]   cnt_next_ext;

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (load) begin
      cnt_d = '0;
      lim_d = (limit_i == '0) ? ONE : limit_i;
    end else if (inc) begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= ONE;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  assign cnt_next_ext = {1'b0, cnt_q} + {1'b0, ONE};
  assign limit_hit    = cnt_next_ext >= {1'b0, lim_q};
endmodule

// File: rtl/tbp_seq.sv
// Sequencer: issues reads one at a time and turns pair verdicts into pulses.
module tbp_seq
  import tbp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic rd_ack_i,
  input  logic toggled,
  input  logic timeout_seen,
  input  logic limit_hit,
  output logic rd_req_o,
  output logic cap_en,
  output logic cnt_load,
  output logic cnt_inc,
  output logic done_o,
  output logic fail_o,
  output logic reset_cmd_o
);
  tbp_state_e state_q, state_d;
  logic recheck_q, recheck_d;
  logic done_q, done_d;
  logic fail_q, fail_d;
  logic rcmd_q, rcmd_d;

  always_comb begin
    state_d   = state_q;
    recheck_d = recheck_q;
    done_d    = 1'b0;
    fail_d    = 1'b0;
    rcmd_d    = 1'b0;
    cap_en    = 1'b0;
    cnt_load  = 1'b0;
    cnt_inc   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_ISSUE_A;
          recheck_d = 1'b0;
          cnt_load  = 1'b1;
        end
      end
      ST_ISSUE_A: state_d = ST_WAIT_A;
      ST_WAIT_A: begin
        if (rd_ack_i) begin
          cap_en  = 1'b1;
          state_d = ST_ISSUE_B;
        end
      end
      ST_ISSUE_B: state_d = ST_WAIT_B;
      ST_WAIT_B: begin
        if (rd_ack_i) begin
          if (!toggled) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (recheck_q) begin
            fail_d  = 1'b1;
            rcmd_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (timeout_seen) begin
            recheck_d = 1'b1;
            state_d   = ST_ISSUE_A;
          end else if (limit_hit) begin
            fail_d  = 1'b1;
            rcmd_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            cnt_inc = 1'b1;
            state_d = ST_ISSUE_A;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      recheck_q <= 1'b0;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
      rcmd_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      recheck_q <= recheck_d;
      done_q    <= done_d;
      fail_q    <= fail_d;
      rcmd_q    <= rcmd_d;
    end
  end

  assign rd_req_o    = (state_q == ST_ISSUE_A) || (state_q == ST_ISSUE_B);
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign reset_cmd_o = rcmd_q;
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int DATA_W      = 8,
  parameter int TOGGLE_IDX  = 6,
  parameter int TIMEOUT_IDX = 5,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  output logic              rd_req_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              done_o,
  output logic              fail_o,
  output logic              reset_cmd_o
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic rst_n_sync;
  logic toggled, timeout_seen, limit_hit;
  logic cap_en, cnt_load, cnt_inc;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[SYNC_STAGES-1];

  tbp_pair_judge #(
    .DATA_W(DATA_W), .TOGGLE_IDX(TOGGLE_IDX), .TIMEOUT_IDX(TIMEOUT_IDX)
  ) u_judge (
    .clk(clk), .rst_n(rst_n_sync), .cap_en(cap_en), .rd_data(rd_data_i),
    .toggled(toggled), .timeout_seen(timeout_seen)
  );

  tbp_poll_limit #(.CNT_W(CNT_W)) u_limit (
    .clk(clk), .rst_n(rst_n_sync), .load(cnt_load), .inc(cnt_inc),
    .limit_i(max_polls_i), .limit_hit(limit_hit)
  );

  tbp_seq u_seq (
    .clk(clk), .rst_n(rst_n_sync), .start_i(start_i), .rd_ack_i(rd_ack_i),
    .toggled(toggled), .timeout_seen(timeout_seen), .limit_hit(limit_hit),
    .rd_req_o(rd_req_o), .cap_en(cap_en), .cnt_load(cnt_load),
    .cnt_inc(cnt_inc), .done_o(done_o), .fail_o(fail_o),
    .reset_cmd_o(reset_cmd_o)
  );
endmodule

// File: rtl/tbp_checker.sv
module tbp_checker (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic rd_req_o,
  input logic rd_ack_i,
  input logic done_o,
  input logic fail_o,
  input logic reset_cmd_o
);
  logic outstanding_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        outstanding_q <= 1'b0;
    else if (rd_req_o) outstanding_q <= 1'b1;
    else if (rd_ack_i) outstanding_q <= 1'b0;
  end

  assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> !outstanding_q);
  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);
  assert_verdict_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fail_o) |-> $past(rd_ack_i));
  assert_fail_with_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> $rose(reset_cmd_o));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_fail_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> !fail_o);
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));
  assert_idle_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_o || fail_o) && !start_i) |=> !rd_req_o);
endmodule

bind toggle_poll_ctrl tbp_checker u_tbp_checker (
  .clk(clk), .rst_n(rst_n_sync), .start_i(start_i), .rd_req_o(rd_req_o),
  .rd_ack_i(rd_ack_i), .done_o(done_o), .fail_o(fail_o),
  .reset_cmd_o(reset_cmd_o)
);

// File: tb/tb_toggle_poll_ctrl.sv
`timescale 1ns/1ps
module tb_toggle_poll_ctrl;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 16;

  typedef struct packed {
    logic [63:0] script;   // status bytes, first read in [7:0]
    logic [3:0]  lat;      // extra response delay in cycles
    logic [7:0]  limit;
    logic [3:0]  nreads;
    logic        exp_fail;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{64'h4040,     4'd0, 8'd8, 4'd2, 1'b0, 4'd3}, // R3 still at once
    '{64'h5A45,     4'd2, 8'd8, 4'd2, 1'b0, 4'd3}, // R3 other bits ignored
    '{64'h404000,   4'd1, 8'd8, 4'd6, 1'b0, 4'd4}, // R4 two changing pairs
    '{64'h20206000, 4'd0, 8'd1, 4'd4, 1'b0, 4'd5}, // R5 recheck settles
    '{64'h20602040, 4'd1, 8'd8, 4'd4, 1'b1, 4'd6}, // R6 recheck still toggling
    '{64'h40004000, 4'd0, 8'd2, 4'd4, 1'b1, 4'd7}, // R7 limit of 2
    '{64'h0040,     4'd2, 8'd0, 4'd2, 1'b1, 4'd7}, // R7 limit 0 acts as 1
    '{64'h40400060, 4'd3, 8'd3, 4'd4, 1'b0, 4'd4}  // R4 bit 5 of first read
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [CNT_W-1:0] max_polls_i;
  logic rd_req_o, rd_ack_i, done_o, fail_o, reset_cmd_o;
  logic [DATA_W-1:0] rd_data_i;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [63:0] dev_script;
  logic [3:0]  dev_lat;
  int          dev_idx;
  int          dev_wait;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  toggle_poll_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .max_polls_i(max_polls_i),
    .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .done_o(done_o), .fail_o(fail_o), .reset_cmd_o(reset_cmd_o)
  );

  // Device model: answers each read after dev_lat idle cycles.
  initial begin
    rd_ack_i = 1'b0; rd_data_i = '0; dev_idx = 0; dev_wait = 0;
    dev_script = '0; dev_lat = '0;
    forever begin
      @(posedge clk);
      begin
        logic r, s;
        r = rd_req_o;
        s = start_i;
        #1;
        rd_ack_i = 1'b0;
        if (s && !r && dev_wait == 0) dev_idx = 0;
        if (r) begin
          if (dev_lat == 0) begin
            rd_ack_i  = 1'b1;
            rd_data_i = dev_script[dev_idx*8 +: 8];
            dev_idx++;
          end else dev_wait = dev_lat;
        end else if (dev_wait > 0) begin
          dev_wait--;
          if (dev_wait == 0) begin
            rd_ack_i  = 1'b1;
            rd_data_i = dev_script[dev_idx*8 +: 8];
            dev_idx++;
          end
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input bit poke_start);
    int nreq, last_ack, verdict_cyc, start_cyc, gap_err;
    bit got_done, got_fail, got_cmd, poked;
    string tg;
    tg = $sformatf("R%0d", v.req);
    dev_script = v.script; dev_lat = v.lat;
    max_polls_i = {8'h00, v.limit};
    nreq = 0; last_ack = -10; verdict_cyc = -1; gap_err = 0;
    got_done = 0; got_fail = 0; got_cmd = 0; poked = 0;
    @(negedge clk); start_i = 1'b1; start_cyc = cyc;
    @(negedge clk); start_i = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (poked) start_i = 1'b0;
      if (rd_req_o) begin
        // R1: first request one cycle after start, later ones one after ack
        if (nreq == 0 && cyc != start_cyc + 1) gap_err++;
        if (nreq > 0 && cyc != last_ack + 1) gap_err++;
        nreq++;
      end
      if (rd_ack_i) last_ack = cyc;
      if (done_o || fail_o) begin
        got_done = done_o; got_fail = fail_o; got_cmd = reset_cmd_o;
        verdict_cyc = cyc;
        break;
      end
      if (poke_start && nreq == 1 && !poked) begin
        start_i = 1'b1; poked = 1;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check({tg, " verdict fail"}, got_fail, v.exp_fail);
    check({tg, " verdict done"}, got_done, !v.exp_fail);
    check({tg, " reset cmd with fail"}, got_cmd, v.exp_fail);
    check({tg, " read count"}, nreq, v.nreads);
    check({tg, " R1 request timing errors"}, gap_err, 0);
    check({tg, " R3 verdict one cycle after ack"}, verdict_cyc - last_ack, 1);
    @(negedge clk);
    // R8: pulse dropped, idle, no new read
    check({tg, " R8 pulse width"}, {done_o, fail_o, reset_cmd_o}, 0);
    repeat (3) begin
      @(negedge clk);
      if (rd_req_o) nreq++;
    end
    check({tg, " R8 no read after verdict"}, nreq, v.nreads);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; max_polls_i = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 outputs in reset", {rd_req_o, done_o, fail_o, reset_cmd_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 outputs after release", {rd_req_o, done_o, fail_o, reset_cmd_o}, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

    // R9: start while busy is ignored (R4 script, long latency)
    run_vec('{64'h404000, 4'd3, 8'd8, 4'd6, 1'b0, 4'd9}, 1'b1);

    // R10: reset during an operation abandons it
    dev_script = 64'h4000_4000; dev_lat = 4'd2; max_polls_i = 16'd8;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R10 outputs during mid-run reset", {rd_req_o, done_o, fail_o, reset_cmd_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    begin
      int seen;
      seen = 0;
      repeat (12) begin
        @(negedge clk);
        if (rd_req_o || done_o || fail_o || reset_cmd_o) seen++;
      end
      check("R10 idle after mid-run reset, stray ack ignored", seen, 0);
    end

    // R3 again after reset: block still works
    run_vec(VECS[0], 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule